// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block runs the control side of a single DMA channel. A parameter chooses whether it is a transmit channel or a receive channel. Software arms the channel by writing one 32-bit configuration word. That word enables the channel, can request an orderly shutdown, can make a receive channel keep polling when it is short of descriptors, and names the queue that receives completed receive descriptors. The engine takes descriptor addresses from a submit-queue handshake. It reads word 0 and word 2 of each 32-byte descriptor through a memory port that returns read data one cycle after the request. It then moves the requested byte count through a handshake that carries only a beat size, rewrites the descriptor with the number of bytes moved, and posts the descriptor address to a completion queue.

A shutdown request is honoured only in a cycle in which no beat is accepted. A descriptor that is in flight at that point is closed and posted first. The engine then writes a self-describing shutdown descriptor at a fixed address, posts it to a fixed queue, and stays parked until software clears the enable bit.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the engine is idle: subReady, memRe, memWe, beatValid and cmplValid are all low.
- R2: While the enable bit (bit 31) is set, the engine pops one submit address. It clears that address's low 5 bits and reads descriptor word 0 at the address and word 2 at the address plus 8. It never reads and writes memory in the same cycle.
- R3: The engine moves the length held in word 0 bits 21:0 as beats of BEAT_BYTES bytes, with a shorter final beat. A beat counts only in a cycle where beatValid and beatReady are both high. A beat is never zero bytes and never larger than BEAT_BYTES.
- R4: When a descriptor ends, the engine rewrites word 0 so that bits 21:0 hold the bytes moved and the upper bits are unchanged. It then posts the descriptor address. A receive channel posts to the queue in configuration bits 11:0. A transmit channel posts to the queue in word 2 bits 11:0.
- R5: A transmit descriptor whose word 2 has bit 19 set (the zero-length flag) produces no beats. Its word 0 is rewritten with length 0.
- R6: On a receive channel, pktEnd in a cycle with no accepted beat ends the packet early and the bytes moved so far are recorded. If no bytes were moved, word 2 is written back with bit 19 set.
- R7: The shutdown request (configuration bit 30) is sampled only in a cycle with no accepted beat. A descriptor in flight at that point is written back and posted before the shutdown descriptor is posted.
- R8: The shutdown descriptor word is 0x98000000, plus bit 16 on a receive channel, plus the port number in bits 4:0. It is written at TD_DESC_ADDR and then posted to TD_QUEUE.
- R9: After a shutdown the engine takes no submit address until the configuration word has been written with bit 31 clear.
- R10: A receive channel with the starvation-retry bit (bit 24) clear polls once after each configuration write or completion. If the submit queue is empty at that poll, it takes nothing more until the next configuration write. With bit 24 set it waits for as long as needed.
- R11: A completion post is a single-cycle cmplValid pulse whose address has its low 5 bits zero.
- R12: With the enable bit clear, no submit address is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration word write strobe |
| cfgWrData | input | 32 | Configuration word value |
| subValid | input | 1 | Submit queue holds a descriptor address |
| subAddr | input | 32 | Submitted descriptor address (low 5 bits ignored) |
| subReady | output | 1 | Submit address popped this cycle |
| memRe | output | 1 | Descriptor memory read request |
| memWe | output | 1 | Descriptor memory write request |
| memAddr | output | 32 | Descriptor memory byte address |
| memWdata | output | 32 | Descriptor memory write data |
| memRdata | input | 32 | Read data, valid the cycle after memRe |
| beatValid | output | 1 | Engine offers a data beat |
| beatBytes | output | BW | Byte count of the offered beat |
| beatReady | input | 1 | Peripheral accepts the beat |
| pktEnd | input | 1 | Receive packet ended (receive channels only) |
| cmplValid | output | 1 | Completion post pulse |
| cmplQueue | output | QUEUE_W | Destination queue of the post |
| cmplAddr | output | 32 | Posted descriptor address |

## Verification
The delicate overlap is a shutdown request that arrives while a receive descriptor is partly transferred. The engine must then close the descriptor, post it, and write and post the shutdown descriptor, all in one run. The bench starts a receive packet, lets exactly one beat through, holds beatReady low and writes the shutdown bit. The scoreboard then expects the data descriptor post with a 4-byte length, followed by the shutdown post carrying the direction and port in its word. A submit address offered afterwards must stay untaken until the enable bit has been cleared.

// File: rtl/chan_dma_pkg.sv
package chan_dma_pkg;

  localparam int CFG_EN_BIT    = 31;
  localparam int CFG_TD_BIT    = 30;
  localparam int CFG_RETRY_BIT = 24;
  localparam int ZLP_BIT       = 19;
  localparam int TD_DIR_BIT    = 16;
  localparam logic [4:0] TYPE_HOST = 5'h10;
  localparam logic [4:0] TYPE_TD   = 5'h13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_WRITEBACK,
    ST_COMPLETE,
    ST_TEARDOWN,
    ST_TDWAIT
  } chanState_e;

  typedef enum logic [1:0] {
    MS_W0,
    MS_W2,
    MS_TD
  } memSel_e;

  typedef struct packed {
    logic    popSub;
    logic    capW0;
    logic    capW2;
    logic    takeBeat;
    logic    memRe;
    logic    memWe;
    memSel_e memSel;
    logic    pushDesc;
    logic    pushTd;
  } chanStrobe_t;

endpackage

// File: rtl/chanCtrl.sv
module chanCtrl
  import chan_dma_pkg::*;
#(
  parameter bit IS_RX = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgWrEnBit,
  input  logic        cfgEn,
  input  logic        cfgTd,
  input  logic        cfgRetry,
  input  logic        subValid,
  input  logic        remZero,
  input  logic        zlpFlag,
  input  logic        beatReady,
  input  logic        pktEnd,
  output logic        subReady,
  output logic        beatValid,
  output chanStrobe_t strobe
);

  chanState_e state, nextState;
  logic [1:0] step, nextStep;
  logic       armed;
  logic       pollOk;

  assign pollOk = armed || !IS_RX || cfgRetry;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextStep  = '0;
    subReady  = 1'b0;
    beatValid = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cfgEn && cfgTd) begin
          nextState = ST_TEARDOWN;
        end else if (cfgEn && pollOk && subValid) begin
          subReady      = 1'b1;
          strobe.popSub = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (step == 2'd0) begin
          strobe.memRe  = 1'b1;
          strobe.memSel = MS_W0;
          nextStep      = 2'd1;
        end else if (step == 2'd1) begin
          strobe.memRe  = 1'b1;
          strobe.memSel = MS_W2;
          strobe.capW0  = 1'b1;
          nextStep      = 2'd2;
        end else begin
          strobe.capW2 = 1'b1;
          nextState    = ST_XFER;
        end
      end
      ST_XFER: begin
        if (zlpFlag || remZero) begin
          nextState = ST_WRITEBACK;
        end else begin
          beatValid = 1'b1;
          if (beatReady) begin
            strobe.takeBeat = 1'b1;
          end else if (cfgTd) begin
            nextState = ST_WRITEBACK;
          end else if (IS_RX && pktEnd) begin
            nextState = ST_WRITEBACK;
          end
        end
      end
      ST_WRITEBACK: begin
        strobe.memWe = 1'b1;
        if (step == 2'd0) begin
          strobe.memSel = MS_W0;
          nextStep      = 2'd1;
        end else begin
          strobe.memSel = MS_W2;
          nextState     = ST_COMPLETE;
        end
      end
      ST_COMPLETE: begin
        strobe.pushDesc = 1'b1;
        nextState = (cfgEn && cfgTd) ? ST_TEARDOWN : ST_IDLE;
      end
      ST_TEARDOWN: begin
        if (step == 2'd0) begin
          strobe.memWe  = 1'b1;
          strobe.memSel = MS_TD;
          nextStep      = 2'd1;
        end else begin
          strobe.pushTd = 1'b1;
          nextState     = ST_TDWAIT;
        end
      end
      ST_TDWAIT: begin
        if (!cfgEn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      step  <= '0;
      armed <= 1'b0;
    end else begin
      state <= nextState;
      step  <= nextStep;
      if (cfgWrEn && cfgWrEnBit) armed <= 1'b1;
      else if (state == ST_COMPLETE) armed <= 1'b1;
      else if (state == ST_IDLE && cfgEn && !subValid && !cfgRetry && IS_RX)
        armed <= 1'b0;
    end
  end

  assert_sub_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    subReady |-> (subValid && cfgEn));

  assert_td_park_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TDWAIT && cfgEn) |=> !subReady);

  assert_td_sample_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && strobe.takeBeat) |=> (state == ST_XFER));

endmodule

// File: rtl/chanDatapath.sv
module chanDatapath
  import chan_dma_pkg::*;
#(
  parameter int          LEN_W        = 22,
  parameter int          QUEUE_W      = 12,
  parameter int          BEAT_BYTES   = 4,
  parameter bit          IS_RX        = 1'b1,
  parameter int          PORT         = 0,
  parameter logic [31:0] TD_DESC_ADDR = 32'h0000_00E0,
  parameter int          TD_QUEUE     = 0,
  localparam int         BW           = $clog2(BEAT_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  chanStrobe_t        strobe,
  input  logic               cfgWrEn,
  input  logic [31:0]        cfgWrData,
  input  logic [31:0]        subAddr,
  input  logic [31:0]        memRdata,
  output logic               cfgEn,
  output logic               cfgTd,
  output logic               cfgRetry,
  output logic               remZero,
  output logic               zlpFlag,
  output logic [BW-1:0]      beatBytes,
  output logic               memRe,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  output logic               cmplValid,
  output logic [QUEUE_W-1:0] cmplQueue,
  output logic [31:0]        cmplAddr
);

  localparam logic [31:0] TD_WORD = (32'(TYPE_TD) << 27)
                                  | (IS_RX ? (32'd1 << TD_DIR_BIT) : 32'd0)
                                  | 32'(PORT % 32);

  logic [31:0]      cfgReg;
  logic [31:0]      descAddr;
  logic [31:0]      word0;
  logic [31:0]      word2;
  logic [LEN_W-1:0] moved;
  logic [LEN_W-1:0] lenField;
  logic [LEN_W-1:0] remaining;
  logic [31:0]      w2Back;
  logic [QUEUE_W-1:0] descQueue;
  logic             addrUnused;
  logic             cfgUnused;

  assign cfgEn    = cfgReg[CFG_EN_BIT];
  assign cfgTd    = cfgReg[CFG_TD_BIT];
  assign cfgRetry = cfgReg[CFG_RETRY_BIT];

  assign lenField  = word0[LEN_W-1:0];
  assign remaining = lenField - moved;
  assign remZero   = (remaining == '0);

  always_comb begin
    if (remaining >= LEN_W'(BEAT_BYTES)) beatBytes = BW'(BEAT_BYTES);
    else                                 beatBytes = remaining[BW-1:0];
  end

  generate
    if (IS_RX) begin : g_rx
      assign zlpFlag   = 1'b0;
      assign descQueue = cfgReg[QUEUE_W-1:0];
      assign w2Back    = word2 | ((moved == '0) ? (32'd1 << ZLP_BIT) : 32'd0);
      assign cfgUnused = ^{cfgReg[29:25], cfgReg[23:QUEUE_W]};
    end else begin : g_tx
      assign zlpFlag   = word2[ZLP_BIT];
      assign descQueue = word2[QUEUE_W-1:0];
      assign w2Back    = word2;
      assign cfgUnused = ^{cfgReg[29:25], cfgReg[23:0]};
    end
  endgenerate

  assign addrUnused = ^subAddr[4:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      descAddr <= '0;
      word0    <= '0;
      word2    <= '0;
      moved    <= '0;
    end else begin
      if (cfgWrEn)       cfgReg   <= cfgWrData;
      if (strobe.popSub) descAddr <= {subAddr[31:5], 5'b0};
      if (strobe.capW0) begin
        word0 <= memRdata;
        moved <= '0;
      end else if (strobe.takeBeat) begin
        moved <= moved + LEN_W'(beatBytes);
      end
      if (strobe.capW2) word2 <= memRdata;
    end
  end

  assign memRe = strobe.memRe;
  assign memWe = strobe.memWe;

  always_comb begin
    case (strobe.memSel)
      MS_W0:   memAddr = descAddr;
      MS_W2:   memAddr = descAddr + 32'd8;
      default: memAddr = TD_DESC_ADDR;
    endcase
    case (strobe.memSel)
      MS_W0:   memWdata = {word0[31:LEN_W], moved};
      MS_W2:   memWdata = w2Back;
      default: memWdata = TD_WORD;
    endcase
  end

  assign cmplValid = strobe.pushDesc | strobe.pushTd;
  assign cmplQueue = strobe.pushTd ? QUEUE_W'(TD_QUEUE) : descQueue;
  assign cmplAddr  = strobe.pushTd ? TD_DESC_ADDR : descAddr;

  assert_mem_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  assert_moved_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    moved <= lenField);

  assert_cmpl_aligned_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> (cmplAddr[4:0] == 5'd0));

  assert_cmpl_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |=> !cmplValid);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import chan_dma_pkg::*;
#(
  parameter int          LEN_W        = 22,
  parameter int          QUEUE_W      = 12,
  parameter int          BEAT_BYTES   = 4,
  parameter bit          IS_RX        = 1'b1,
  parameter int          PORT         = 0,
  parameter logic [31:0] TD_DESC_ADDR = 32'h0000_00E0,
  parameter int          TD_QUEUE     = 0,
  localparam int         BW           = $clog2(BEAT_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [31:0]        cfgWrData,
  input  logic               subValid,
  input  logic [31:0]        subAddr,
  output logic               subReady,
  output logic               memRe,
  output logic               memWe,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWdata,
  input  logic [31:0]        memRdata,
  output logic               beatValid,
  output logic [BW-1:0]      beatBytes,
  input  logic               beatReady,
  input  logic               pktEnd,
  output logic               cmplValid,
  output logic [QUEUE_W-1:0] cmplQueue,
  output logic [31:0]        cmplAddr
);

  chanStrobe_t strobe;
  logic cfgEn, cfgTd, cfgRetry, remZero, zlpFlag;

  chanCtrl #(.IS_RX(IS_RX)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrEnBit(cfgWrData[CFG_EN_BIT]),
    .cfgEn     (cfgEn),
    .cfgTd     (cfgTd),
    .cfgRetry  (cfgRetry),
    .subValid  (subValid),
    .remZero   (remZero),
    .zlpFlag   (zlpFlag),
    .beatReady (beatReady),
    .pktEnd    (pktEnd),
    .subReady  (subReady),
    .beatValid (beatValid),
    .strobe    (strobe)
  );

  chanDatapath #(
    .LEN_W       (LEN_W),
    .QUEUE_W     (QUEUE_W),
    .BEAT_BYTES  (BEAT_BYTES),
    .IS_RX       (IS_RX),
    .PORT        (PORT),
    .TD_DESC_ADDR(TD_DESC_ADDR),
    .TD_QUEUE    (TD_QUEUE)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .subAddr  (subAddr),
    .memRdata (memRdata),
    .cfgEn    (cfgEn),
    .cfgTd    (cfgTd),
    .cfgRetry (cfgRetry),
    .remZero  (remZero),
    .zlpFlag  (zlpFlag),
    .beatBytes(beatBytes),
    .memRe    (memRe),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .cmplValid(cmplValid),
    .cmplQueue(cmplQueue),
    .cmplAddr (cmplAddr)
  );

  assert_beat_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> (beatBytes != '0 && beatBytes <= BW'(BEAT_BYTES)));

endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/100ps

module descMemModel (
  input  logic        clk,
  input  logic        re,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] mem [0:63];
  initial for (int i = 0; i < 64; i++) mem[i] = 32'd0;
  initial rdata = 32'd0;
  always @(posedge clk) begin
    if (we) mem[addr[7:2]] <= wdata;
    if (re) rdata <= mem[addr[7:2]];
  end
endmodule

module dma_chan_engine_test;
  localparam int QW = 12;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int applied = 0;
  int bad = 0;
  bit finished = 1'b0;

  // receive instance
  logic rCfgWe = 0; logic [31:0] rCfgD = 0;
  logic rSubV = 0; logic [31:0] rSubA = 0; logic rSubR;
  logic rRe, rWe; logic [31:0] rAddr, rWd, rRd;
  logic rBv; logic [BW-1:0] rBb; logic rBr = 0; logic rEnd = 0;
  logic rCv; logic [QW-1:0] rCq; logic [31:0] rCa;

  // transmit instance
  logic tCfgWe = 0; logic [31:0] tCfgD = 0;
  logic tSubV = 0; logic [31:0] tSubA = 0; logic tSubR;
  logic tRe, tWe; logic [31:0] tAddr, tWd, tRd;
  logic tBv; logic [BW-1:0] tBb; logic tBr = 0; logic tEnd = 0;
  logic tCv; logic [QW-1:0] tCq; logic [31:0] tCa;

  dma_chan_engine #(.IS_RX(1'b1), .PORT(3), .TD_DESC_ADDR(32'hE0), .TD_QUEUE(31)) uut (
    .clk(clk), .rstN(rstN), .cfgWrEn(rCfgWe), .cfgWrData(rCfgD),
    .subValid(rSubV), .subAddr(rSubA), .subReady(rSubR),
    .memRe(rRe), .memWe(rWe), .memAddr(rAddr), .memWdata(rWd), .memRdata(rRd),
    .beatValid(rBv), .beatBytes(rBb), .beatReady(rBr), .pktEnd(rEnd),
    .cmplValid(rCv), .cmplQueue(rCq), .cmplAddr(rCa));

  dma_chan_engine #(.IS_RX(1'b0), .PORT(5), .TD_DESC_ADDR(32'hC0), .TD_QUEUE(30)) uutTx (
    .clk(clk), .rstN(rstN), .cfgWrEn(tCfgWe), .cfgWrData(tCfgD),
    .subValid(tSubV), .subAddr(tSubA), .subReady(tSubR),
    .memRe(tRe), .memWe(tWe), .memAddr(tAddr), .memWdata(tWd), .memRdata(tRd),
    .beatValid(tBv), .beatBytes(tBb), .beatReady(tBr), .pktEnd(tEnd),
    .cmplValid(tCv), .cmplQueue(tCq), .cmplAddr(tCa));

  descMemModel memRx (.clk(clk), .re(rRe), .we(rWe), .addr(rAddr), .wdata(rWd), .rdata(rRd));
  descMemModel memTx (.clk(clk), .re(tRe), .we(tWe), .addr(tAddr), .wdata(tWd), .rdata(tRd));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard: expected {queue, addr}
  logic [43:0] expRx[$];
  logic [43:0] expTx[$];
  int popsRx = 0, popsTx = 0;
  int bytesRx = 0, bytesTx = 0;

  always @(negedge clk) begin
    if (rstN && rCv) begin
      if (expRx.size() == 0) check(1'b0, "R4 rx unexpected post", {20'd0, rCq}, 32'd0);
      else begin
        logic [43:0] e;
        e = expRx.pop_front();
        check({rCq, rCa} == e, "R4/R11 rx post addr", rCa, e[31:0]);
        check(rCq == e[43:32], "R4 rx post queue", {20'd0, rCq}, {20'd0, e[43:32]});
      end
      popsRx++;
    end
    if (rstN && tCv) begin
      if (expTx.size() == 0) check(1'b0, "R4 tx unexpected post", {20'd0, tCq}, 32'd0);
      else begin
        logic [43:0] e;
        e = expTx.pop_front();
        check({tCq, tCa} == e, "R4/R11 tx post addr", tCa, e[31:0]);
        check(tCq == e[43:32], "R4 tx post queue", {20'd0, tCq}, {20'd0, e[43:32]});
      end
      popsTx++;
    end
    if (rstN && rBv && rBr) bytesRx += int'(rBb);
    if (rstN && tBv && tBr) bytesTx += int'(tBb);
  end

  task automatic cfgRx(input logic [31:0] v);
    @(posedge clk); #1 rCfgWe = 1; rCfgD = v;
    @(posedge clk); #1 rCfgWe = 0;
  endtask
  task automatic cfgTx(input logic [31:0] v);
    @(posedge clk); #1 tCfgWe = 1; tCfgD = v;
    @(posedge clk); #1 tCfgWe = 0;
  endtask

  task automatic submitRx(input logic [31:0] a);
    @(posedge clk); #1 rSubV = 1; rSubA = a;
    forever begin @(negedge clk); if (rSubR) break; end
    @(posedge clk); #1 rSubV = 0;
  endtask
  task automatic submitTx(input logic [31:0] a);
    @(posedge clk); #1 tSubV = 1; tSubA = a;
    forever begin @(negedge clk); if (tSubR) break; end
    @(posedge clk); #1 tSubV = 0;
  endtask

  task automatic giveRxBeats(input int n);
    int got = 0;
    @(posedge clk); #1 rBr = 1;
    while (got < n) begin @(negedge clk); if (rBv) got++; end
    @(posedge clk); #1 rBr = 0;
  endtask

  task automatic waitRx(input int n);
    while (popsRx < n) @(negedge clk);
  endtask
  task automatic waitTx(input int n);
    while (popsTx < n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; applied++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    int b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!rSubR && !rRe && !rWe && !rBv && !rCv, "R1 rx idle", {27'd0, rSubR, rRe, rWe, rBv, rCv}, 32'd0);
    check(!tSubR && !tRe && !tWe && !tBv && !tCv, "R1 tx idle", {27'd0, tSubR, tRe, tWe, tBv, tCv}, 32'd0);

    // R12 disabled channel takes nothing
    @(posedge clk); #1 rSubV = 1; rSubA = 32'h80;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check(!rSubR, "R12 disabled no pop", {31'd0, rSubR}, 32'd0);
    end
    @(posedge clk); #1 rSubV = 0;

    // R2/R3/R4 transmit normal, submitted address with low bits set
    memTx.mem[16] = 32'h8000000A; memTx.mem[18] = 32'h1400002A;
    cfgTx(32'h8000_0000);
    #1 tBr = 1;
    expTx.push_back({12'h02A, 32'h40});
    submitTx(32'h43);
    waitTx(1);
    check(bytesTx == 10, "R3 tx bytes moved", bytesTx, 10);
    @(negedge clk);
    check(memTx.mem[16] == 32'h8000000A, "R4 tx word0 writeback", memTx.mem[16], 32'h8000000A);

    // R5 transmit zero-length flag
    memTx.mem[24] = 32'h80000008; memTx.mem[26] = 32'h1408002A;
    b0 = bytesTx;
    expTx.push_back({12'h02A, 32'h60});
    submitTx(32'h60);
    waitTx(2);
    check(bytesTx == b0, "R5 tx zlp no beats", bytesTx - b0, 0);
    @(negedge clk);
    check(memTx.mem[24] == 32'h80000000, "R5 tx zlp length 0", memTx.mem[24], 32'h80000000);

    // R8 transmit teardown while idle
    expTx.push_back({12'd30, 32'hC0});
    cfgTx(32'hC000_0000);
    waitTx(3);
    @(negedge clk);
    check(memTx.mem[48] == 32'h98000005, "R8 tx teardown word", memTx.mem[48], 32'h98000005);

    // R4 receive normal (queue from config)
    memRx.mem[32] = 32'h8000000C; memRx.mem[34] = 32'h1400007B;
    cfgRx(32'h8100_407B);
    #1 rBr = 1;
    expRx.push_back({12'h07B, 32'h80});
    submitRx(32'h80);
    waitRx(1);
    check(bytesRx == 12, "R3 rx bytes moved", bytesRx, 12);
    #1 rBr = 0;
    @(negedge clk);
    check(memRx.mem[32] == 32'h8000000C, "R4 rx word0 writeback", memRx.mem[32], 32'h8000000C);

    // R6 receive early end after 8 bytes
    memRx.mem[40] = 32'h80000010; memRx.mem[42] = 32'h1400007B;
    b0 = bytesRx;
    expRx.push_back({12'h07B, 32'hA0});
    submitRx(32'hA0);
    giveRxBeats(2);
    #1 rEnd = 1;
    waitRx(2);
    @(posedge clk); #1 rEnd = 0;
    @(negedge clk);
    check(bytesRx - b0 == 8, "R6 rx early bytes", bytesRx - b0, 8);
    check(memRx.mem[40] == 32'h80000008, "R6 rx early length", memRx.mem[40], 32'h80000008);
    check(memRx.mem[42] == 32'h1400007B, "R6 rx word2 no zlp", memRx.mem[42], 32'h1400007B);

    // R6 receive zero-length packet
    memRx.mem[8] = 32'h80000004; memRx.mem[10] = 32'h1400007B;
    @(posedge clk); #1 rEnd = 1;
    expRx.push_back({12'h07B, 32'h20});
    submitRx(32'h20);
    waitRx(3);
    @(posedge clk); #1 rEnd = 0;
    @(negedge clk);
    check(memRx.mem[8] == 32'h80000000, "R6 rx zlp length", memRx.mem[8], 32'h80000000);
    check(memRx.mem[10] == 32'h1408007B, "R6 rx zlp flag", memRx.mem[10], 32'h1408007B);

    // R7/R8 teardown during a receive transfer
    memRx.mem[16] = 32'h80000014; memRx.mem[18] = 32'h1400007B;
    expRx.push_back({12'h07B, 32'h40});
    expRx.push_back({12'd31, 32'hE0});
    submitRx(32'h40);
    giveRxBeats(1);
    cfgRx(32'hC100_407B);
    waitRx(5);
    @(negedge clk);
    check(memRx.mem[16] == 32'h80000004, "R7 rx in-flight length", memRx.mem[16], 32'h80000004);
    check(memRx.mem[56] == 32'h98010003, "R8 rx teardown word", memRx.mem[56], 32'h98010003);

    // R9 parked after teardown
    memRx.mem[24] = 32'h80000004; memRx.mem[26] = 32'h1400007B;
    @(posedge clk); #1 rSubV = 1; rSubA = 32'h60;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check(!rSubR, "R9 parked no pop", {31'd0, rSubR}, 32'd0);
    end
    @(posedge clk); #1 rSubV = 0;
    cfgRx(32'h0);
    repeat (2) @(posedge clk);
    cfgRx(32'h8100_407B);
    #1 rBr = 1;
    expRx.push_back({12'h07B, 32'h60});
    submitRx(32'h60);
    waitRx(6);
    #1 rBr = 0;

    // R10 receive without starvation retry polls once
    memRx.mem[32] = 32'h80000004; memRx.mem[34] = 32'h1400007B;
    cfgRx(32'h8000_407B);
    repeat (3) @(posedge clk);
    #1 rSubV = 1; rSubA = 32'h80;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check(!rSubR, "R10 no re-poll", {31'd0, rSubR}, 32'd0);
    end
    #1 rBr = 1;
    expRx.push_back({12'h07B, 32'h80});
    cfgRx(32'h8000_407B);
    forever begin @(negedge clk); if (rSubR) break; end
    check(rSubR, "R10 poll after config write", {31'd0, rSubR}, 32'd1);
    @(posedge clk); #1 rSubV = 0;
    waitRx(7);
    #1 rBr = 0;

    repeat (4) @(posedge clk);
    check(expRx.size() == 0 && expTx.size() == 0, "R4 all posts seen",
          expRx.size() + expTx.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule